// File: doc/BRIEF.md
# Input capture timer

This block pairs a free-running 16-bit count with an input capture register. The count advances by one on every timer tick, and a tick comes every `TICK_DIV` clocks. The external capture pin passes through a synchroniser and then an edge detector. One control bit chooses whether a rising or a falling edge is the active edge.

When an active edge is recognised, the count value of that timer state is held. At the next tick that value is moved into the capture register and the capture flag is set. A processor reads the 16-bit value as two bytes through a small register port, high byte first. Reading the high byte locks the capture register until the low byte is read. This keeps both bytes from the same event. The shortest pulse period software can measure is therefore set by how fast it completes the byte pair. Reading the low byte by itself never blocks a capture.

Registers (2-bit address, single-cycle strobes, combinational read data):

| Address | Contents |
|---|---|
| 0 | control, read/write; bit 0 selects the edge (0 = rising, 1 = falling) |
| 1 | status, read-only; bit 7 is the capture flag |
| 2 | capture bits 15:8 |
| 3 | capture bits 7:0 |

Top module: `icap_timer`

## Requirements
- R1: After reset the count is 0xFFFC, the capture register is 0, the flag is clear, the lock is released and control bit 0 is 0 (rising edge).
- R2: The count increases by exactly one on each timer tick, one tick every TICK_DIV clocks, and wraps from 0xFFFF to 0x0000.
- R3: The pin is sampled through SYNC_STAGES flops. Only the edge selected by control bit 0 (address 0) triggers a capture, and the opposite edge leaves the capture register and the flag unchanged.
- R4: The captured value is the count value of the clock cycle in which the synchronised edge is seen. It is written at the next tick, and the flag (status bit 7) rises on that same tick.
- R5: A read of address 2 returns capture bits 15:8 and sets the lock. While the lock is set the capture register does not change. A read of address 3 returns bits 7:0 and releases the lock.
- R6: An active edge that lands while the lock is set is dropped without being queued, but it still sets the flag.
- R7: A read of address 3 with no preceding read of address 2 does not set the lock, so a later edge is captured.
- R8: The flag clears only when a read of address 1 that returned the flag set is followed by a read of address 3. A read of address 3 without that status read leaves the flag set.
- R9: Writes to addresses 1, 2 and 3 have no effect on the status or on the capture value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The bench builds the block with TICK_DIV = 3, a two-flop synchroniser and the 0xFFFC reset count. With this prescaler, every phase of an edge within a timer state can be swept for both edge polarities in a few hundred cycles. Because the count starts just below wrap, the first captures cross 0xFFFF to 0x0000. Expected capture values and the tick in which the flag rises are worked out from the number of clock edges since reset.

// File: rtl/icap_pkg.sv
// Shared definitions for the input capture timer.
// Assumes an 8-bit register port over a 16-bit capture value.
package icap_pkg;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int FLAG_BIT = 7;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_CAPH = 2'd2,
        RA_CAPL = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/icap_tickgen.sv
// Prescaler and free-running count.
// A tick pulses for one clock every TICK_DIV clocks, and the count advances on it.
// Assumes TICK_DIV >= 1.
module icap_tickgen #(
    parameter int                      TICK_DIV  = 4,
    parameter logic [icap_pkg::CNT_W-1:0] RST_COUNT = 16'hFFFC
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic                       tick,
    output logic [icap_pkg::CNT_W-1:0] cnt_q
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0] pre_q;

    assign tick = (pre_q == PW'(TICK_DIV - 1));

    // prescaler: counts clocks within one timer state
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // timebase: advances once per timer state and wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= RST_COUNT;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/icap_pin_sync.sv
// Synchroniser and edge detector for the capture pin.
// Produces a one-clock pulse on the selected edge of the synchronised pin.
// Assumes the pin is low during reset and SYNC_STAGES >= 2.
module icap_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_hit
);
    logic [SYNC_STAGES:0] sh_q;
    logic                 now_lvl;
    logic                 old_lvl;

    // shift chain: synchronising stages plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
    end

    assign now_lvl  = sh_q[SYNC_STAGES-1];
    assign old_lvl  = sh_q[SYNC_STAGES];
    assign edge_hit = fall_sel ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
endmodule

// File: rtl/icap_capture.sv
// Capture register, capture flag and the high/low byte read lock.
// A recognised edge is held until the next tick and moved in then unless locked.
// The flag is set even when the lock drops the transfer.
// Assumes single-cycle read strobes that are already decoded.
module icap_capture (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       edge_hit,
    input  logic [icap_pkg::CNT_W-1:0] cnt,
    input  logic                       rd_hi,
    input  logic                       rd_lo,
    input  logic                       rd_stat,
    output logic [icap_pkg::CNT_W-1:0] cap_q,
    output logic                       flag_q,
    output logic                       lock_q,
    output logic                       armed_q
);
    logic pend_q;
    logic evt;

    assign evt = tick & (pend_q | edge_hit);

    // pending edge: remembered until the timer state ends
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (tick)     pend_q <= 1'b0;
        else if (edge_hit) pend_q <= 1'b1;
    end

    // capture register: loaded at the tick unless the lock holds it
    always_ff @(posedge clk) begin
        if (!rst_n)              cap_q <= '0;
        else if (evt && !lock_q) cap_q <= cnt;
    end

    // lock: set by a high-byte read, released by a low-byte read
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_q <= 1'b0;
        else if (rd_hi) lock_q <= 1'b1;
        else if (rd_lo) lock_q <= 1'b0;
    end

    // clear arm: a status read that saw the flag enables the clear
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (rd_stat) armed_q <= flag_q;
        else if (rd_lo)   armed_q <= 1'b0;
    end

    // flag: set on every capture event, and a set beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (evt)              flag_q <= 1'b1;
        else if (rd_lo && armed_q) flag_q <= 1'b0;
    end
endmodule

// File: rtl/icap_timer.sv
// Top of the input capture timer: register decode, edge-select control,
// read multiplexer, and the three sub-blocks.
// Assumes single-cycle bus strobes; read data is combinational on bus_addr.
module icap_timer #(
    parameter int                         TICK_DIV    = 4,
    parameter logic [icap_pkg::CNT_W-1:0] RST_COUNT   = 16'hFFFC,
    parameter int                         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_pin,
    input  logic [1:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    import icap_pkg::*;

    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;
    logic             lock_q;
    logic             armed_q;
    logic             edge_hit;
    logic             fall_sel_q;
    logic             rd_hi;
    logic             rd_lo;
    logic             rd_stat;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata[7:1];
    assign rd_hi   = bus_rd && (bus_addr == RA_CAPH);
    assign rd_lo   = bus_rd && (bus_addr == RA_CAPL);
    assign rd_stat = bus_rd && (bus_addr == RA_STAT);

    // control register: edge select, the only writable bit
    always_ff @(posedge clk) begin
        if (!rst_n)                             fall_sel_q <= 1'b0;
        else if (bus_wr && bus_addr == RA_CTRL) fall_sel_q <= bus_wdata[0];
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTRL: bus_rdata[0]        = fall_sel_q;
            RA_STAT: bus_rdata[FLAG_BIT] = flag_q;
            RA_CAPH: bus_rdata           = cap_q[CNT_W-1:BYTE_W];
            default: bus_rdata           = cap_q[BYTE_W-1:0];
        endcase
    end

    icap_tickgen #(.TICK_DIV(TICK_DIV), .RST_COUNT(RST_COUNT)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q)
    );

    icap_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .fall_sel(fall_sel_q),
        .edge_hit(edge_hit)
    );

    icap_capture u_cap (
        .clk(clk), .rst_n(rst_n), .tick(tick), .edge_hit(edge_hit),
        .cnt(cnt_q), .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_stat(rd_stat),
        .cap_q(cap_q), .flag_q(flag_q), .lock_q(lock_q), .armed_q(armed_q)
    );
endmodule

// Temporal checks on the capture timer, attached by bind.
module icap_timer_chk #(
    parameter logic [15:0] RST_COUNT = 16'hFFFC
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic [1:0]  bus_addr,
    input logic        tick,
    input logic [15:0] cnt_q,
    input logic [15:0] cap_q,
    input logic        flag_q,
    input logic        lock_q,
    input logic        armed_q
);
    logic rd_hi_s;
    logic rd_lo_s;

    assign rd_hi_s = bus_rd && (bus_addr == 2'd2);
    assign rd_lo_s = bus_rd && (bus_addr == 2'd3);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == RST_COUNT && cap_q == 16'h0 && !flag_q && !lock_q));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == 16'($past(cnt_q) + 16'd1));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    // R4
    cap_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_q) |-> ($past(tick) && flag_q));

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(cap_q));

    // R5
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_s |=> lock_q);

    // R7
    lock_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_s |=> !lock_q);

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(rd_lo_s && armed_q)) |=> flag_q);
endmodule

bind icap_timer icap_timer_chk #(.RST_COUNT(RST_COUNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .tick(tick), .cnt_q(cnt_q), .cap_q(cap_q), .flag_q(flag_q),
    .lock_q(lock_q), .armed_q(armed_q)
);

// File: tb/icap_timer_test.sv
`timescale 1ns/1ps
module icap_timer_test;
    localparam int          D   = 3;
    localparam logic [15:0] RST = 16'hFFFC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_pin = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int ncyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

    icap_timer #(.TICK_DIV(D), .RST_COUNT(RST), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // drive the active level; return the expected value and the flag tick
    task automatic fire(input logic lvl, output logic [15:0] exp, output int t);
        int j;
        @(negedge clk);
        cap_pin = lvl;
        j = ncyc;
        exp = 16'(RST + 16'((j + 2) / D));
        t = ((j + 3 + D - 1) / D) * D;
    endtask

    task automatic settle();
        repeat (D + 4) @(negedge clk);
    endtask

    task automatic read_pair(output logic [15:0] v);
        logic [7:0] h;
        logic [7:0] l;
        rd(2'd2, h);
        rd(2'd3, l);
        v = {h, l};
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v;
        logic [15:0] ea;
        logic [15:0] eb;
        logic [15:0] ec;
        int          t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state seen at the ports
        peek(2'd0, d); check(16'(d), 16'h00, "R1 ctrl");
        peek(2'd1, d); check(16'(d), 16'h00, "R1 status");
        peek(2'd2, d); check(16'(d), 16'h00, "R1 cap hi");
        peek(2'd3, d); check(16'(d), 16'h00, "R1 cap lo");

        // R2 R3 R4 sweep over tick phase and edge polarity, across the wrap
        for (int ph = 0; ph < 2 * D; ph++) begin
            for (int pol = 0; pol < 2; pol++) begin
                wr(2'd0, 8'(pol));
                rd(2'd0, d); check(16'(d), 16'(pol), "R3 ctrl readback");
                cap_pin = (pol == 1);
                repeat (4) @(negedge clk);
                repeat (ph) @(negedge clk);
                fire(pol == 0, ea, t);
                settle();
                read_pair(v);
                check(v, ea, "R2 R4 captured count");
                if (pol == 1) begin
                    cap_pin = 1'b1;
                    settle();
                    read_pair(v);
                    check(v, ea, "R3 opposite edge ignored");
                end
            end
        end

        // R8 clear, then R4 flag timing against the tick
        wr(2'd0, 8'h00);
        cap_pin = 1'b0;
        settle();
        rd(2'd1, d);
        rd(2'd3, d);
        rd(2'd1, d); check(16'(d), 16'h00, "R8 flag cleared by status then low read");
        fire(1'b1, ea, t);
        while (ncyc < t - 1) @(negedge clk);
        peek(2'd1, d); check(16'(d), 16'h00, "R4 flag low before tick");
        @(negedge clk);
        peek(2'd1, d); check(16'(d), 16'h80, "R4 flag high at tick");
        settle();
        read_pair(v); check(v, ea, "R4 value at flag tick");

        // R5 R6 interlock
        cap_pin = 1'b0; settle();
        fire(1'b1, ea, t); settle();
        rd(2'd2, d); check(16'(d), 16'(ea[15:8]), "R5 high byte");
        cap_pin = 1'b0; settle();
        fire(1'b1, eb, t); settle();
        rd(2'd1, d); check(16'(d), 16'h80, "R6 flag set on dropped edge");
        rd(2'd3, d); check(16'(d), 16'(ea[7:0]), "R5 low byte same event");
        repeat (2 * D + 4) @(negedge clk);
        read_pair(v); check(v, ea, "R6 dropped edge not queued");

        // R7 low read alone does not lock
        rd(2'd3, d);
        cap_pin = 1'b0; settle();
        fire(1'b1, ec, t); settle();
        read_pair(v); check(v, ec, "R7 capture after low-only read");

        // R8 low read without status read leaves the flag; R9 writes ignored
        rd(2'd3, d);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h55);
        wr(2'd3, 8'hAA);
        rd(2'd1, d); check(16'(d), 16'h80, "R8 R9 flag kept");
        rd(2'd3, d);
        rd(2'd1, d); check(16'(d), 16'h00, "R8 flag cleared");
        read_pair(v); check(v, ec, "R9 capture unchanged by writes");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule